// File: doc/BRIEF.md
# Accumulator ALU Execution Unit

This block is the arithmetic and logic datapath of a small 8-bit controller. It takes a stream of instruction bytes, one per clock when `byte_valid` is high, and runs each recognised instruction against an 8-bit accumulator. The second operand can come from one of three places: an immediate byte that follows the opcode, a working register R0-R7 in the selected bank, or a byte of resident RAM whose address is held in R0 or R1. The block keeps a carry flag, an auxiliary (nibble) carry flag and a one-bit register-bank selector. It also supports decimal adjust, rotates, a nibble swap and a low-nibble exchange with indirect RAM.

Working registers are not separate storage. They are the bottom bytes of the resident RAM. Bank 0 places R0-R7 at addresses 0-7 and bank 1 places them at 24-31. A preload port lets the surrounding logic (or a test bench) write any RAM byte directly. Program flow, timers and ports are handled elsewhere. Any byte that is not a recognised opcode is consumed with no effect.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator, carry, auxiliary carry and bank select are 0, and every resident RAM byte reads as 0.
- R2: Opcodes 0x03 (add), 0x13 (add with carry), 0x53 (AND), 0x43 (OR) and 0xD3 (XOR) take the next valid byte as immediate data. The accumulator and flags hold until that data byte arrives, and the result appears on the clock edge that accepts it. Idle cycles in between are allowed.
- R3: Register add is 01101rrr and register add-with-carry is 01111rrr. Both write the low 8 bits of A + operand (+ C for the carry form) into A. C takes the carry out of bit 7 and AC takes the carry out of bit 3.
- R4: Register AND is 01011rrr, OR is 01001rrr and XOR is 11011rrr. Logic operations, in every addressing form, leave C and AC unchanged.
- R5: The indirect forms are add 0110000r, add-with-carry 0111000r, AND 0101000r, OR 0100000r and XOR 1101000r. In each, bit 0 selects R0 or R1 of the current bank, and the low address bits of that register's value (6 bits for the default 64-byte RAM) address the operand.
- R6: Opcode 0xC5 selects bank 0 and 0xD5 selects bank 1. Rr resolves to RAM address r in bank 0 and to 24+r in bank 1.
- R7: 0x27 clears A and 0x37 inverts A. 0x97 clears C and 0xA7 inverts C. Other state is left as it was.
- R8: 0x67 rotates right through carry: old C goes into bit 7 and old bit 0 goes into C. 0xE7 rotates A left with bit 7 moving into bit 0, and C is unchanged.
- R9: 0x47 exchanges the two nibbles of A. 0011000r exchanges bits 3:0 of A with bits 3:0 of the indirectly addressed RAM byte, and the upper nibbles stay in place.
- R10: For decimal adjust (0x57), 0x06 is added first if the low nibble is above 9 or AC is 1. Then 0x60 is added if the resulting high nibble is above 9 or C is 1, and that second step sets C. C is never cleared by this instruction, and AC is unchanged.
- R11: A cycle with `byte_valid` low, or an undefined opcode (for example 0x01), changes no state.
- R12: When `ld_en` is high, `ld_data` is written to RAM address `ld_addr`. If an instruction writes the same byte in the same cycle, the preload value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Instruction stream byte present this cycle |
| byte_in | input | 8 | Opcode or immediate data byte |
| ld_en | input | 1 | Resident RAM preload write enable |
| ld_addr | input | 6 | Preload address (log2 of RAM depth) |
| ld_data | input | 8 | Preload data |
| acc_o | output | 8 | Accumulator |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| bank_o | output | 1 | Selected register bank |

## Verification
Most internal faults in this block appear on `acc_o` on the edge right after the instruction that uses them. A wrong bank base or pointer decode changes the operand of the next register or indirect instruction. A stuck pending-immediate flag makes a data byte get decoded as an opcode, and the error shows one edge later. A corrupted RAM write, such as a wrong exchange nibble, stays hidden until a later instruction reads that byte. For that reason the test program reads each written byte back through an add after the exchange. A wrong carry or nibble carry may also stay hidden until an add-with-carry or decimal adjust consumes it, so the sequence chains those instructions directly after the flags are set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_ADDC,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_DA
    } alu_op_e;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_ALU,
        CLS_PEND,
        CLS_CLRA,
        CLS_CPLA,
        CLS_CLRC,
        CLS_CPLC,
        CLS_RRC,
        CLS_RL,
        CLS_SWAP,
        CLS_XCHD,
        CLS_BANK
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        alu_op_e    op;
        logic       indirect;
        logic [2:0] rsel;
        logic       bank_val;
    } dec_t;

    typedef struct packed {
        logic [7:0] acc;
        logic       cy;
        logic       ac;
        logic       bank;
        logic       pend;
        alu_op_e    pend_op;
    } state_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec          = '0;
        dec.cls      = CLS_NONE;
        dec.op       = ALU_ADD;
        dec.rsel     = opcode[2:0];
        dec.indirect = 1'b0;
        dec.bank_val = opcode[4];
        casez (opcode)
            8'h03: begin dec.cls = CLS_PEND; dec.op = ALU_ADD;  end
            8'h13: begin dec.cls = CLS_PEND; dec.op = ALU_ADDC; end
            8'h53: begin dec.cls = CLS_PEND; dec.op = ALU_AND;  end
            8'h43: begin dec.cls = CLS_PEND; dec.op = ALU_OR;   end
            8'hD3: begin dec.cls = CLS_PEND; dec.op = ALU_XOR;  end
            8'b01101???: begin dec.cls = CLS_ALU; dec.op = ALU_ADD;  end
            8'b01111???: begin dec.cls = CLS_ALU; dec.op = ALU_ADDC; end
            8'b01011???: begin dec.cls = CLS_ALU; dec.op = ALU_AND;  end
            8'b01001???: begin dec.cls = CLS_ALU; dec.op = ALU_OR;   end
            8'b11011???: begin dec.cls = CLS_ALU; dec.op = ALU_XOR;  end
            8'b0110000?: begin dec.cls = CLS_ALU; dec.op = ALU_ADD;  dec.indirect = 1'b1; end
            8'b0111000?: begin dec.cls = CLS_ALU; dec.op = ALU_ADDC; dec.indirect = 1'b1; end
            8'b0101000?: begin dec.cls = CLS_ALU; dec.op = ALU_AND;  dec.indirect = 1'b1; end
            8'b0100000?: begin dec.cls = CLS_ALU; dec.op = ALU_OR;   dec.indirect = 1'b1; end
            8'b1101000?: begin dec.cls = CLS_ALU; dec.op = ALU_XOR;  dec.indirect = 1'b1; end
            8'b0011000?: begin dec.cls = CLS_XCHD; dec.indirect = 1'b1; end
            8'h57: begin dec.cls = CLS_ALU; dec.op = ALU_DA; end
            8'h27: dec.cls = CLS_CLRA;
            8'h37: dec.cls = CLS_CPLA;
            8'h97: dec.cls = CLS_CLRC;
            8'hA7: dec.cls = CLS_CPLC;
            8'h67: dec.cls = CLS_RRC;
            8'hE7: dec.cls = CLS_RL;
            8'h47: dec.cls = CLS_SWAP;
            8'hC5, 8'hD5: dec.cls = CLS_BANK;
            default: dec.cls = CLS_NONE;
        endcase
        if (dec.indirect) begin
            dec.rsel = {2'b00, opcode[0]};
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_op_e    op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic       cy_in,
    input  logic       ac_in,
    output logic [7:0] res,
    output logic       cy_out,
    output logic       ac_out
);
    logic       cadd;
    logic [8:0] sum9;
    logic [4:0] lo5;
    logic [7:0] da_t;

    always_comb begin
        cadd   = (op == ALU_ADDC) ? cy_in : 1'b0;
        sum9   = {1'b0, a} + {1'b0, b} + {8'd0, cadd};
        lo5    = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cadd};
        da_t   = ((a[3:0] > 4'd9) || ac_in) ? (a + 8'h06) : a;
        res    = a;
        cy_out = cy_in;
        ac_out = ac_in;
        unique case (op)
            ALU_ADD, ALU_ADDC: begin
                res    = sum9[7:0];
                cy_out = sum9[8];
                ac_out = lo5[4];
            end
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_XOR: res = a ^ b;
            ALU_DA: begin
                if ((da_t[7:4] > 4'd9) || cy_in) begin
                    res    = da_t + 8'h60;
                    cy_out = 1'b1;
                end else begin
                    res    = da_t;
                end
            end
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int RAM_DEPTH  = 64,
    parameter int BANK1_BASE = 24,
    localparam int AW        = $clog2(RAM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    output logic [7:0]    acc_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          bank_o
);
    state_t        state_q, state_d;
    logic [7:0]    ram_q [RAM_DEPTH];
    logic [7:0]    ram_d [RAM_DEPTH];

    dec_t          dec;
    logic [AW-1:0] reg_addr, ind_addr;
    logic [7:0]    reg_val, ind_val, opnd;
    alu_op_e       alu_op;
    logic [7:0]    alu_res;
    logic          alu_cy, alu_ac;

    acc_alu_decode u_dec (
        .opcode (byte_in),
        .dec    (dec)
    );

    always_comb begin
        reg_addr = state_q.bank ? AW'(BANK1_BASE + int'(dec.rsel)) : AW'(dec.rsel);
        reg_val  = ram_q[reg_addr];
        ind_addr = reg_val[AW-1:0];
        ind_val  = ram_q[ind_addr];
        opnd     = state_q.pend ? byte_in : (dec.indirect ? ind_val : reg_val);
        alu_op   = state_q.pend ? state_q.pend_op : dec.op;
    end

    acc_alu_core u_core (
        .op     (alu_op),
        .a      (state_q.acc),
        .b      (opnd),
        .cy_in  (state_q.cy),
        .ac_in  (state_q.ac),
        .res    (alu_res),
        .cy_out (alu_cy),
        .ac_out (alu_ac)
    );

    always_comb begin
        state_d = state_q;
        ram_d   = ram_q;
        if (byte_valid) begin
            if (state_q.pend) begin
                state_d.acc  = alu_res;
                state_d.cy   = alu_cy;
                state_d.ac   = alu_ac;
                state_d.pend = 1'b0;
            end else begin
                unique case (dec.cls)
                    CLS_PEND: begin
                        state_d.pend    = 1'b1;
                        state_d.pend_op = dec.op;
                    end
                    CLS_ALU: begin
                        state_d.acc = alu_res;
                        state_d.cy  = alu_cy;
                        state_d.ac  = alu_ac;
                    end
                    CLS_CLRA: state_d.acc = 8'h00;
                    CLS_CPLA: state_d.acc = ~state_q.acc;
                    CLS_CLRC: state_d.cy  = 1'b0;
                    CLS_CPLC: state_d.cy  = ~state_q.cy;
                    CLS_RRC: begin
                        state_d.acc = {state_q.cy, state_q.acc[7:1]};
                        state_d.cy  = state_q.acc[0];
                    end
                    CLS_RL:   state_d.acc = {state_q.acc[6:0], state_q.acc[7]};
                    CLS_SWAP: state_d.acc = {state_q.acc[3:0], state_q.acc[7:4]};
                    CLS_XCHD: begin
                        state_d.acc     = {state_q.acc[7:4], ind_val[3:0]};
                        ram_d[ind_addr] = {ind_val[7:4], state_q.acc[3:0]};
                    end
                    CLS_BANK: state_d.bank = dec.bank_val;
                    default: ;
                endcase
            end
        end
        if (ld_en) begin
            ram_d[ld_addr] = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            ram_q   <= '{default: '0};
        end else begin
            state_q <= state_d;
            ram_q   <= ram_d;
        end
    end

    assign acc_o  = state_q.acc;
    assign cy_o   = state_q.cy;
    assign ac_o   = state_q.ac;
    assign bank_o = state_q.bank;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic [7:0] byte_in,
    input logic       pend_q,
    input logic [7:0] acc_o,
    input logic       cy_o,
    input logic       ac_o,
    input logic       bank_o
);
    logic op_now;
    assign op_now = byte_valid && !pend_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(acc_o) && $stable(cy_o) && $stable(ac_o) && $stable(bank_o)); // R11
    AST_IMM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h03 |=> pend_q && $stable(acc_o) && $stable(cy_o)); // R2
    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in[7:3] == 5'b01011 |=> $stable(cy_o) && $stable(ac_o)); // R4
    AST_BANK0_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'hC5 |=> !bank_o); // R6
    AST_BANK1_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'hD5 |=> bank_o); // R6
    AST_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h97 |=> !cy_o); // R7
    AST_CLR_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h27 |=> acc_o == 8'h00); // R7
    AST_RRC_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h67 |=>
        cy_o == $past(acc_o[0]) && acc_o == {$past(cy_o), $past(acc_o[7:1])}); // R8
    AST_RL_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'hE7 |=>
        $stable(cy_o) && acc_o == {$past(acc_o[6:0]), $past(acc_o[7])}); // R8
    AST_SWAP_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h47 |=> acc_o == {$past(acc_o[3:0]), $past(acc_o[7:4])}); // R9
    AST_DA_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        op_now && byte_in == 8'h57 && cy_o |=> cy_o && $stable(ac_o)); // R10
endmodule

bind acc_alu_unit acc_alu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .pend_q     (state_q.pend),
    .acc_o      (acc_o),
    .cy_o       (cy_o),
    .ac_o       (ac_o),
    .bank_o     (bank_o)
);

// File: tb/acc_alu_unit_test.sv
module acc_alu_unit_test;
    localparam int AW = 6;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] imm;
        logic       two;
        logic [7:0] a;
        logic       c;
        logic       ac;
        logic       bk;
        logic [3:0] req;
    } vec_t;

    // Sequential program; each row lists the state expected after it.
    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{8'h03, 8'h3A, 1'b1, 8'h3A, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 add imm
        '{8'h6A, 8'h00, 1'b0, 8'h76, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 AC from bit 3
        '{8'h6B, 8'h00, 1'b0, 8'h3B, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 carry out
        '{8'h7A, 8'h00, 1'b0, 8'h78, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 addc uses C
        '{8'h13, 8'h88, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 addc imm
        '{8'h60, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 add @R0
        '{8'h53, 8'hF0, 1'b1, 8'h50, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 and imm
        '{8'h4A, 8'h00, 1'b0, 8'h7C, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 or reg
        '{8'hDB, 8'h00, 1'b0, 8'hB9, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 xor reg
        '{8'h51, 8'h00, 1'b0, 8'h99, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 and @R1
        '{8'hD1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 xor @R1
        '{8'h43, 8'h81, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 or imm
        '{8'hD3, 8'hFF, 1'b1, 8'h7E, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 xor imm
        '{8'h37, 8'h00, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 cpl A
        '{8'hA7, 8'h00, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 cpl C
        '{8'h67, 8'h00, 1'b0, 8'hC0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 rrc
        '{8'hE7, 8'h00, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 rl
        '{8'h97, 8'h00, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clr C
        '{8'h47, 8'h00, 1'b0, 8'h18, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 swap
        '{8'h27, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clr A
        '{8'h70, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 addc @R0
        '{8'h57, 8'h00, 1'b0, 8'h60, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 low fix
        '{8'h6B, 8'h00, 1'b0, 8'h25, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        '{8'h57, 8'h00, 1'b0, 8'h85, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 high via C
        '{8'h97, 8'h00, 1'b0, 8'h85, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h6A, 8'h00, 1'b0, 8'hC1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
        '{8'h57, 8'h00, 1'b0, 8'h27, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 both fixes
        '{8'hD5, 8'h00, 1'b0, 8'h27, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 bank 1
        '{8'h68, 8'h00, 1'b0, 8'h49, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 R0 at 24
        '{8'h6A, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 R2 at 26
        '{8'h30, 8'h00, 1'b0, 8'h5F, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 xchd
        '{8'h60, 8'h00, 1'b0, 8'h69, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 RAM got 0A
        '{8'hC5, 8'h00, 1'b0, 8'h69, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 bank 0
        '{8'h6A, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 4'd6},  // R6
        '{8'h01, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 4'd11}  // R11 undefined
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = 8'h00;
    logic [7:0]    acc_o;
    logic          cy_o, ac_o, bank_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    acc_alu_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .acc_o      (acc_o),
        .cy_o       (cy_o),
        .ac_o       (ac_o),
        .bank_o     (bank_o)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] st();
        return {5'd0, acc_o, cy_o, ac_o, bank_o};
    endfunction

    function automatic logic [15:0] mk(logic [7:0] a, logic c, logic h, logic b);
        return {5'd0, a, c, h, b};
    endfunction

    task automatic load(logic [AW-1:0] addr, logic [7:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = addr; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic issue(logic [7:0] op, logic [7:0] imm, logic two);
        @(negedge clk);
        byte_valid = 1'b1; byte_in = op;
        if (two) begin
            @(negedge clk);
            byte_in = imm;
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", st(), mk(8'h00, 1'b0, 1'b0, 1'b0));
        rst_n = 1'b1;
        issue(8'h6D, 8'h00, 1'b0);  // R1: RAM cleared, R5 adds zero
        chk("R1 RAM zero", st(), mk(8'h00, 1'b0, 1'b0, 1'b0));

        // R12 preload of registers and data bytes
        load(6'd0, 8'h20); load(6'd1, 8'h21); load(6'd2, 8'h3C); load(6'd3, 8'hC5);
        load(6'h20, 8'h5A); load(6'h21, 8'h99);
        load(6'd24, 8'h22); load(6'd26, 8'h11); load(6'h22, 8'h0F);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].imm, VEC[i].two);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), st(),
                mk(VEC[i].a, VEC[i].c, VEC[i].ac, VEC[i].bk));
        end

        // R11 idle cycles hold everything
        repeat (5) @(negedge clk);
        chk("R11 idle hold", st(), mk(8'hA5, 1'b0, 1'b1, 1'b0));

        // R2 pending immediate waits across gaps
        @(negedge clk); byte_valid = 1'b1; byte_in = 8'h03;
        @(negedge clk); byte_valid = 1'b0; byte_in = 8'h27;
        repeat (2) @(negedge clk);
        chk("R2 hold while waiting", st(), mk(8'hA5, 1'b0, 1'b1, 1'b0));
        byte_valid = 1'b1; byte_in = 8'h01;
        @(negedge clk); byte_valid = 1'b0;
        chk("R2 late data byte", st(), mk(8'hA6, 1'b0, 1'b0, 1'b0));

        // R5 pointer uses only low address bits: 0x61 -> 0x21
        load(6'd1, 8'h61);
        issue(8'h27, 8'h00, 1'b0);
        issue(8'h61, 8'h00, 1'b0);
        chk("R5 pointer wrap", st(), mk(8'h99, 1'b0, 1'b0, 1'b0));

        // R12 preload beats exchange write to the same byte
        @(negedge clk);
        byte_valid = 1'b1; byte_in = 8'h30;
        ld_en = 1'b1; ld_addr = 6'h20; ld_data = 8'h77;
        @(negedge clk);
        byte_valid = 1'b0; ld_en = 1'b0;
        chk("R9 xchd low nibble", st(), mk(8'h9A, 1'b0, 1'b0, 1'b0));
        issue(8'h27, 8'h00, 1'b0);
        issue(8'h60, 8'h00, 1'b0);
        chk("R12 preload priority", st(), mk(8'h77, 1'b0, 1'b0, 1'b0));

        // R10 decimal adjust keeps C set even with no correction needed
        issue(8'hA7, 8'h00, 1'b0);
        issue(8'h27, 8'h00, 1'b0);
        issue(8'h57, 8'h00, 1'b0);
        chk("R10 C never cleared", st(), mk(8'h60, 1'b1, 1'b0, 1'b0));

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule